// File: doc/BRIEF.md
# HDLC Transmit Chunk Feeder

The block carries one outgoing D-channel frame from a host frame buffer into a 32-byte transmit FIFO window of an HDLC controller. A host asks for a transfer by presenting the frame length. The block then reads the bytes through a read port on the frame buffer and writes them into the window. After each chunk it issues a transmit command word. The controller answers each chunk with a pool-ready event. When the last chunk has been taken, the block gives the upper layer a frame-sent confirmation.

A frame longer than the window is split into full 32-byte pieces, with a shorter tail at the end. Only the final piece carries the message-end flag. The controller can report a data underrun or ask for the message to be repeated. Either event moves the read position back to byte zero, so the whole frame goes out again. A frame is only taken when the layer-1 link reports the activated state and the length is nonzero. Only one frame may be in flight at a time.

Top module: `hdlc_tx_feeder`

## Requirements
- R1: Each chunk holds min(remaining, 32) bytes. The bytes are written with `fifo_wr` one per cycle, at window offsets 0 upward. They are read from consecutive buffer addresses, starting at the first byte not yet sent (the frame starts at address 0), and `fifo_data` equals `buf_data` at `buf_addr`.
- R2: A chunk that is not the last one is committed by a one-cycle `cmd_send` pulse, in the cycle after its last byte, with `cmd_last`=0.
- R3: The final chunk of a frame is committed by `cmd_send` with `cmd_last`=1.
- R4: A `pool_ready` pulse while waiting after a command starts the next chunk if bytes remain; its first byte write is visible after the next clock edge. If no bytes remain, `sent_ok` pulses for one cycle after the next edge and `busy` drops in the same cycle.
- R5: `underrun` or `repeat_req` while waiting rewinds the frame to byte 0. Without `pool_ready` nothing is written. A `pool_ready` that follows, or that comes in the same cycle, loads the chunk starting at byte 0, even if every byte had already been committed.
- R6: A request (`req_valid` with `req_len`) made while idle, with `link_up`=1 and a nonzero length, is answered by `req_accept` one cycle later. The first byte write appears in that same cycle.
- R7: A request while `busy`=1 is answered by `req_error` one cycle later and leaves the frame in flight unchanged.
- R8: A `pool_ready` while idle has no effect: no write, no command, no confirmation, and `busy` stays 0.
- R9: A request with `link_up`=0 or with `req_len`=0 is answered by `req_reject` one cycle later and starts no transfer.
- R10: After reset, `busy`, `fifo_wr`, `cmd_send`, `sent_ok` and all three request responses are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| link_up | input | 1 | Layer-1 link is in the activated state |
| req_valid | input | 1 | Frame request strobe |
| req_len | input | LEN_W | Frame length in bytes |
| req_accept | output | 1 | Request taken |
| req_reject | output | 1 | Request refused (link down or zero length) |
| req_error | output | 1 | Request while a frame is in flight |
| buf_addr | output | LEN_W | Frame buffer read address |
| buf_data | input | 8 | Frame buffer read data, combinational on `buf_addr` |
| fifo_wr | output | 1 | Window byte write strobe |
| fifo_idx | output | IDX_W | Window offset of the byte written |
| fifo_data | output | 8 | Byte written into the window |
| cmd_send | output | 1 | Transmit command strobe for the loaded chunk |
| cmd_last | output | 1 | Message-end flag qualifying `cmd_send` |
| pool_ready | input | 1 | Controller reports the window free |
| underrun | input | 1 | Controller reports a transmit data underrun |
| repeat_req | input | 1 | Controller asks for the message to be repeated |
| sent_ok | output | 1 | Frame-sent confirmation pulse |
| busy | output | 1 | A frame is in flight |

## Verification
The two functions that can meet in one cycle are the rewind (underrun or repeat) and the pool-ready advance. The bench raises both together after every chunk position of frames sized around the 32-byte boundaries, including after the final chunk, where an advance alone would confirm. The judgement is that the rewind wins: the next chunk must start at byte 0 with a full-size count, and no confirmation may appear before the frame has been committed again to its end.

// File: rtl/hdlc_tx_feeder.sv
module hdlc_tx_feeder #(
  parameter int LEN_W = 10,
  parameter int CHUNK = 32,
  localparam int IDX_W = $clog2(CHUNK)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             link_up,
  input  logic             req_valid,
  input  logic [LEN_W-1:0] req_len,
  output logic             req_accept,
  output logic             req_reject,
  output logic             req_error,
  output logic [LEN_W-1:0] buf_addr,
  input  logic [7:0]       buf_data,
  output logic             fifo_wr,
  output logic [IDX_W-1:0] fifo_idx,
  output logic [7:0]       fifo_data,
  output logic             cmd_send,
  output logic             cmd_last,
  input  logic             pool_ready,
  input  logic             underrun,
  input  logic             repeat_req,
  output logic             sent_ok,
  output logic             busy
);

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_CMD, S_WAIT} st_t;

  st_t              st;
  logic [LEN_W-1:0] frm_len;
  logic [LEN_W-1:0] base;
  logic [IDX_W-1:0] idx;
  logic [IDX_W:0]   cnt;

  function automatic logic [IDX_W:0] chunk_of(input logic [LEN_W-1:0] rem);
    if (rem > LEN_W'(CHUNK)) return (IDX_W+1)'(CHUNK);
    return rem[IDX_W:0];
  endfunction

  wire              rewind   = underrun | repeat_req;
  wire [LEN_W-1:0]  eff_base = rewind ? '0 : base;
  wire [LEN_W-1:0]  eff_rem  = frm_len - eff_base;
  wire [LEN_W-1:0]  base_nxt = base + LEN_W'(cnt);

  assign busy      = (st != S_IDLE);
  assign fifo_wr   = (st == S_LOAD);
  assign fifo_idx  = idx;
  assign buf_addr  = base + LEN_W'(idx);
  assign fifo_data = buf_data;
  assign cmd_send  = (st == S_CMD);
  assign cmd_last  = cmd_send && (base_nxt == frm_len);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      frm_len    <= '0;
      base       <= '0;
      idx        <= '0;
      cnt        <= '0;
      req_accept <= 1'b0;
      req_reject <= 1'b0;
      req_error  <= 1'b0;
      sent_ok    <= 1'b0;
    end else begin
      req_accept <= 1'b0;
      req_reject <= 1'b0;
      req_error  <= 1'b0;
      sent_ok    <= 1'b0;

      if (req_valid) begin
        if (st != S_IDLE)                   req_error  <= 1'b1;
        else if (!link_up || req_len == '0) req_reject <= 1'b1;
        else                                req_accept <= 1'b1;
      end

      case (st)
        S_IDLE: if (req_valid && link_up && req_len != '0) begin
          frm_len <= req_len;
          base    <= '0;
          idx     <= '0;
          cnt     <= chunk_of(req_len);
          st      <= S_LOAD;
        end
        S_LOAD: begin
          if ({1'b0, idx} == cnt - 1'b1) begin
            idx <= '0;
            st  <= S_CMD;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        S_CMD: begin
          base <= base_nxt;
          st   <= S_WAIT;
        end
        S_WAIT: begin
          if (rewind) base <= '0;
          if (pool_ready) begin
            if (eff_rem != '0) begin
              cnt <= chunk_of(eff_rem);
              idx <= '0;
              st  <= S_LOAD;
            end else begin
              sent_ok <= 1'b1;
              st      <= S_IDLE;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

module hdlc_tx_feeder_chk #(
  parameter int LEN_W = 10,
  parameter int IDX_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             link_up,
  input logic [LEN_W-1:0] req_len,
  input logic             req_accept,
  input logic             req_reject,
  input logic             req_error,
  input logic [LEN_W-1:0] buf_addr,
  input logic             fifo_wr,
  input logic             cmd_send,
  input logic             pool_ready,
  input logic             sent_ok,
  input logic             busy
);

  assert_contig_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr && $past(fifo_wr) |-> buf_addr == $past(buf_addr) + 1'b1);

  assert_cmd_then_wait_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_send |=> !fifo_wr && !cmd_send);

  assert_confirm_after_pool_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sent_ok |-> $past(pool_ready) && !busy);

  assert_accept_needs_link_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_accept |-> $past(link_up) && $past(req_len) != '0 && fifo_wr);

  assert_one_response_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({req_accept, req_reject, req_error}));

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !fifo_wr && !cmd_send);

endmodule

bind hdlc_tx_feeder hdlc_tx_feeder_chk #(.LEN_W(LEN_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .link_up(link_up), .req_len(req_len),
  .req_accept(req_accept), .req_reject(req_reject), .req_error(req_error),
  .buf_addr(buf_addr), .fifo_wr(fifo_wr), .cmd_send(cmd_send),
  .pool_ready(pool_ready), .sent_ok(sent_ok), .busy(busy)
);

// File: tb/sim_hdlc_tx_feeder.sv
`timescale 1ns/1ps
module sim_hdlc_tx_feeder;
  localparam int LEN_W = 10;
  localparam int CHUNK = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic link_up = 1'b1;
  logic req_valid = 1'b0;
  logic [LEN_W-1:0] req_len = '0;
  logic pool_ready = 1'b0, underrun = 1'b0, repeat_req = 1'b0;
  logic req_accept, req_reject, req_error, fifo_wr, cmd_send, cmd_last, sent_ok, busy;
  logic [LEN_W-1:0] buf_addr;
  logic [7:0] buf_data, fifo_data;
  logic [4:0] fifo_idx;
  logic [7:0] seed = 8'd0;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  assign buf_data = 8'(buf_addr * 13) ^ seed;

  hdlc_tx_feeder #(.LEN_W(LEN_W), .CHUNK(CHUNK)) u0 (
    .clk(clk), .rst_n(rst_n), .link_up(link_up), .req_valid(req_valid), .req_len(req_len),
    .req_accept(req_accept), .req_reject(req_reject), .req_error(req_error),
    .buf_addr(buf_addr), .buf_data(buf_data), .fifo_wr(fifo_wr), .fifo_idx(fifo_idx),
    .fifo_data(fifo_data), .cmd_send(cmd_send), .cmd_last(cmd_last),
    .pool_ready(pool_ready), .underrun(underrun), .repeat_req(repeat_req),
    .sent_ok(sent_ok), .busy(busy));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic quiet(input string req);
    chk(!fifo_wr && !cmd_send && !sent_ok, req, {fifo_wr, cmd_send, sent_ok}, 0);
  endtask

  // mode: 0 plain, 1 underrun, 2 repeat, 3 underrun with pool_ready same cycle, 4 busy request
  task automatic run_frame(input int len, input int at_chunk, input int mode);
    int pos, cstart, nb, chunk_no, guard, exp_n;
    bit done, hit;
    seed = seed + 8'd37;
    req_valid = 1'b1; req_len = LEN_W'(len);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_accept == 1'b1 && busy == 1'b1, "R6 accept", req_accept, 1);
    pos = 0; cstart = 0; nb = 0; chunk_no = 0; guard = 0; done = 0; hit = 0;
    while (!done && guard < 5000) begin
      guard++;
      if (fifo_wr) begin
        chk(fifo_data == (8'(pos * 13) ^ seed) && buf_addr == LEN_W'(pos), "R1 data",
            fifo_data, 8'(pos * 13) ^ seed);
        chk(fifo_idx == 5'(nb), "R1 window offset", fifo_idx, nb);
        pos++; nb++;
      end
      if (cmd_send) begin
        exp_n = (len - cstart > CHUNK) ? CHUNK : len - cstart;
        chk(nb == exp_n, "R1 chunk size", nb, exp_n);
        if (pos == len) chk(cmd_last == 1'b1, "R3 final chunk end flag", cmd_last, 1);
        else            chk(cmd_last == 1'b0, "R2 middle chunk no end flag", cmd_last, 0);
        cstart = pos; nb = 0; chunk_no++;
        @(negedge clk);
        if (!hit && chunk_no == at_chunk && mode == 4) begin
          hit = 1;
          req_valid = 1'b1; req_len = LEN_W'(3);
          @(negedge clk);
          req_valid = 1'b0;
          chk(req_error == 1'b1 && req_accept == 1'b0, "R7 busy request error", req_error, 1);
          quiet("R7 frame untouched");
        end
        if (!hit && chunk_no == at_chunk && mode != 0) begin
          hit = 1;
          underrun = (mode != 2); repeat_req = (mode == 2); pool_ready = (mode == 3);
          pos = 0; cstart = 0;
          @(negedge clk);
          underrun = 1'b0; repeat_req = 1'b0; pool_ready = 1'b0;
          if (mode != 3) begin
            quiet("R5 rewind alone waits");
            chk(busy == 1'b1, "R5 still busy", busy, 1);
            pool_ready = 1'b1;
            @(negedge clk);
            pool_ready = 1'b0;
          end
          chk(fifo_wr == 1'b1 && buf_addr == '0, "R5 restart at byte 0", buf_addr, 0);
          continue;
        end
        pool_ready = 1'b1;
        @(negedge clk);
        pool_ready = 1'b0;
        if (cstart == len) begin
          chk(sent_ok == 1'b1 && busy == 1'b0, "R4 confirm", sent_ok, 1);
          done = 1;
        end else begin
          chk(fifo_wr == 1'b1, "R4 next chunk starts", fifo_wr, 1);
        end
        continue;
      end
      @(negedge clk);
    end
    chk(done, "R4 frame completes", done, 1);
    @(negedge clk);
    quiet("R4 idle after confirm");
  endtask

  task automatic refused(input bit link, input int len, input string req);
    link_up = link; req_valid = 1'b1; req_len = LEN_W'(len);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_reject == 1'b1 && req_accept == 1'b0, req, req_reject, 1);
    chk(busy == 1'b0 && !fifo_wr, req, busy, 0);
    @(negedge clk);
    quiet(req);
    link_up = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !fifo_wr && !cmd_send && !sent_ok && !req_accept && !req_reject && !req_error,
        "R10 reset state", busy, 0);
    rst_n = 1'b1;
    @(negedge clk);

    pool_ready = 1'b1;
    @(negedge clk);
    pool_ready = 1'b0;
    quiet("R8 idle pool_ready");
    chk(busy == 1'b0, "R8 stays idle", busy, 0);
    @(negedge clk);
    quiet("R8 idle pool_ready later");

    refused(1'b0, 10, "R9 link down reject");
    refused(1'b1, 0, "R9 zero length reject");

    for (int len = 1; len <= 100; len++) run_frame(len, 0, 0);

    for (int li = 0; li < 8; li++) begin
      int len, nch;
      case (li)
        0: len = 1;  1: len = 31; 2: len = 32; 3: len = 33;
        4: len = 64; 5: len = 65; 6: len = 96; default: len = 97;
      endcase
      nch = (len + CHUNK - 1) / CHUNK;
      for (int c = 1; c <= nch; c++)
        for (int m = 1; m <= 3; m++) run_frame(len, c, m);
    end

    run_frame(40, 1, 4);
    run_frame(70, 2, 4);
    run_frame(5, 1, 4);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule